// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block runs a 10-bit successive-approximation conversion for a small ADC peripheral. Software controls it through four byte-wide registers. The block drives the sample/hold switch and the trial code for an external DAC. It reads back a single comparator bit. A conversion-clock enable pulse, `conv_tick_i`, marks each conversion period. The sequencer advances only on cycles where that pulse is high.

Software writes the start bit to begin a conversion. The block opens the sample switch and resolves one result bit per period, MSB first. When all bits are resolved, it stores the code in a high/low register pair, either left- or right-justified. It then clears the busy indication, closes the switch and raises a sticky completion flag. The interrupt line is that flag gated by an enable bit.

Software may abandon a conversion by clearing the busy bit or the enable bit. The result registers then keep their previous contents. A short recovery delay follows, and acquisition resumes by itself once the delay ends.

Top module: `adc_seq_ctrl`

## Requirements
- R1: Address 0 is control: bit 0 enable, bit 1 start/busy, bit 2 format (0 left, 1 right), bit 3 interrupt enable, bit 4 completion flag, bits 7:5 read 0. Address 1 is the result high byte, address 2 the result low byte, and address 3 reads 0. After reset every register reads 0, `irq_o` is 0 and `sample_o` is 0.
- R2: A control write with bits 0 and 1 both set, while enable is already 1 and no conversion or recovery is running, starts a conversion. Bit 1 reads 1 from the next cycle until completion, and `sample_o` is 0 during that time.
- R3: A start write is ignored while enable is 0. This includes a single write that sets enable and start together.
- R4: A conversion spans exactly 11 `conv_tick_i` periods and tries bits MSB first. A trial bit is kept when `cmp_i` is 1 (input at or above the trial code) and cleared otherwise, so the result equals the input code.
- R5: On completion, the result registers load, bit 1 clears, bit 4 sets and `sample_o` returns to 1, all on the same edge.
- R6: The format bit in force when the result loads selects the layout. When it is 0, high = result[9:2] and low = {result[1:0], 000000}. When it is 1, high = {000000, result[9:8]} and low = result[7:0].
- R7: The completion flag is sticky. A control write with bit 4 = 0 clears it, and bit 4 = 1 leaves it unchanged. `irq_o` equals flag AND interrupt enable.
- R8: A control write that clears bit 1 during a conversion abandons it. Both result registers and the flag keep their previous values.
- R9: After an abort, `sample_o` stays 0 for 2 `conv_tick_i` periods and then returns to 1 by itself. Start writes during this delay are ignored.
- R10: Clearing enable during a conversion abandons it as in R8 and holds `sample_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address for write and read |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` (combinational) |
| conv_tick_i | input | 1 | Conversion-clock enable, one pulse per period |
| cmp_i | input | 1 | Comparator: 1 when input is at or above trial code |
| sample_o | output | 1 | Sample/hold switch closed (acquiring) |
| dac_code_o | output | 10 | Trial code to the DAC |
| irq_o | output | 1 | Completion interrupt |

## Verification
The hardest state to reach from the ports is the recovery window after an abort. Reaching it takes a conversion that is part-way resolved, an abort write between two conversion ticks, and then a start attempt that lands inside the two-period delay. The bench counts the conversion ticks it issues, times the abort and the retry against that count, and watches `sample_o` on every cycle until the delay has elapsed. Disabling mid-conversion is reached the same way, and randomized input codes exercise both result layouts.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_CONV, ST_RECOV} seq_state_e;

  localparam int unsigned CTRL_EN   = 0;
  localparam int unsigned CTRL_GO   = 1;
  localparam int unsigned CTRL_FMT  = 2;
  localparam int unsigned CTRL_IE   = 3;
  localparam int unsigned CTRL_FLAG = 4;

  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_RES_HI = 2'd1;
  localparam logic [1:0] ADDR_RES_LO = 2'd2;
endpackage

// File: rtl/adc_sar_core.sv
module adc_sar_core #(
  parameter int unsigned RES_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             step_i,
  input  logic             cmp_i,
  output logic [RES_W-1:0] code_o,
  output logic             last_o,
  output logic [RES_W-1:0] result_o
);
  localparam int unsigned STEP_W = $clog2(RES_W + 1);
  localparam logic [RES_W-1:0] MSB_ONLY = {1'b1, {(RES_W-1){1'b0}}};

  logic [STEP_W-1:0] step_q;
  logic [RES_W-1:0]  code_q, code_d;

  // step 0 only sets the MSB trial; step k resolves bit RES_W-k and tries the next
  always_comb begin
    code_d = code_q;
    for (int i = 0; i < RES_W; i++) begin
      if (step_q != '0 && i == int'(RES_W) - int'(step_q)) code_d[i] = cmp_i;
      if (int'(step_q) < int'(RES_W) && i == int'(RES_W) - 1 - int'(step_q)) code_d[i] = 1'b1;
    end
  end

  assign last_o   = (step_q == STEP_W'(RES_W));
  assign code_o   = code_q;
  assign result_o = code_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= '0;
      code_q <= '0;
    end else if (clear_i) begin
      step_q <= '0;
      code_q <= '0;
    end else if (step_i) begin
      code_q <= code_d;
      if (!last_o) step_q <= step_q + 1'b1;
    end
  end

  // R4
  sar_msb_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !clear_i && step_q == '0) |=> (code_q == MSB_ONLY));
endmodule

// File: rtl/adc_result_pack.sv
module adc_result_pack #(
  parameter int unsigned RES_W  = 10,
  parameter int unsigned DATA_W = 8
) (
  input  logic [RES_W-1:0]  res_i,
  input  logic              right_i,
  output logic [DATA_W-1:0] hi_o,
  output logic [DATA_W-1:0] lo_o
);
  localparam int unsigned PACK_W = 2 * DATA_W;

  logic [PACK_W-1:0] left_w, right_w, sel_w;

  generate
    if (PACK_W > RES_W) begin : g_pad
      assign left_w  = {res_i, {(PACK_W-RES_W){1'b0}}};
      assign right_w = {{(PACK_W-RES_W){1'b0}}, res_i};
    end else begin : g_full
      assign left_w  = res_i[RES_W-1 -: PACK_W];
      assign right_w = res_i[PACK_W-1:0];
    end
  endgenerate

  assign sel_w = right_i ? right_w : left_w;
  assign hi_o  = sel_w[PACK_W-1:DATA_W];
  assign lo_o  = sel_w[DATA_W-1:0];
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int unsigned RES_W       = 10,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned RECOV_TICKS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              conv_tick_i,
  input  logic              cmp_i,
  output logic              sample_o,
  output logic [RES_W-1:0]  dac_code_o,
  output logic              irq_o
);
  localparam int unsigned RCNT_W = (RECOV_TICKS > 1) ? $clog2(RECOV_TICKS) : 1;

  seq_state_e        state_q, state_d;
  logic              en_q, fmt_q, ie_q, flag_q;
  logic [RCNT_W-1:0] rcnt_q, rcnt_d;
  logic [DATA_W-1:0] res_hi_q, res_lo_q, pack_hi, pack_lo;
  logic [RES_W-1:0]  sar_result;
  logic              sar_last;
  logic              wr_ctrl, start_req, abort_req, conv_step, done;
  logic              unused_wdata;

  assign unused_wdata = ^wdata_i[DATA_W-1:CTRL_FLAG+1];

  assign wr_ctrl   = wr_en_i && (addr_i == ADDR_CTRL);
  // start needs enable already set by an earlier write
  assign start_req = wr_ctrl && wdata_i[CTRL_GO] && wdata_i[CTRL_EN] && en_q
                     && (state_q == ST_IDLE);
  assign abort_req = wr_ctrl && (state_q == ST_CONV)
                     && (!wdata_i[CTRL_GO] || !wdata_i[CTRL_EN]);
  assign conv_step = (state_q == ST_CONV) && conv_tick_i && !abort_req;
  assign done      = conv_step && sar_last;

  adc_sar_core #(.RES_W(RES_W)) i_sar (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (start_req),
    .step_i   (conv_step),
    .cmp_i    (cmp_i),
    .code_o   (dac_code_o),
    .last_o   (sar_last),
    .result_o (sar_result)
  );

  adc_result_pack #(.RES_W(RES_W), .DATA_W(DATA_W)) i_pack (
    .res_i   (sar_result),
    .right_i (fmt_q),
    .hi_o    (pack_hi),
    .lo_o    (pack_lo)
  );

  always_comb begin
    state_d = state_q;
    rcnt_d  = rcnt_q;
    unique case (state_q)
      ST_IDLE:  if (start_req) state_d = ST_CONV;
      ST_CONV: begin
        if (abort_req) begin
          state_d = ST_RECOV;
          rcnt_d  = '0;
        end else if (done) begin
          state_d = ST_IDLE;
        end
      end
      ST_RECOV: if (conv_tick_i) begin
        if (rcnt_q == RCNT_W'(RECOV_TICKS - 1)) begin
          state_d = ST_IDLE;
          rcnt_d  = '0;
        end else begin
          rcnt_d = rcnt_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      rcnt_q   <= '0;
      en_q     <= 1'b0;
      fmt_q    <= 1'b0;
      ie_q     <= 1'b0;
      flag_q   <= 1'b0;
      res_hi_q <= '0;
      res_lo_q <= '0;
    end else begin
      state_q <= state_d;
      rcnt_q  <= rcnt_d;
      if (wr_ctrl) begin
        en_q  <= wdata_i[CTRL_EN];
        fmt_q <= wdata_i[CTRL_FMT];
        ie_q  <= wdata_i[CTRL_IE];
      end
      if (done)                                flag_q <= 1'b1;
      else if (wr_ctrl && !wdata_i[CTRL_FLAG]) flag_q <= 1'b0;
      if (done) begin
        res_hi_q <= pack_hi;
        res_lo_q <= pack_lo;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_CTRL: begin
        rdata_o[CTRL_EN]   = en_q;
        rdata_o[CTRL_GO]   = (state_q == ST_CONV);
        rdata_o[CTRL_FMT]  = fmt_q;
        rdata_o[CTRL_IE]   = ie_q;
        rdata_o[CTRL_FLAG] = flag_q;
      end
      ADDR_RES_HI: rdata_o = res_hi_q;
      ADDR_RES_LO: rdata_o = res_lo_q;
      default:     rdata_o = '0;
    endcase
  end

  assign sample_o = en_q && (state_q == ST_IDLE);
  assign irq_o    = flag_q && ie_q;

  // R8
  res_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done |=> ($stable(res_hi_q) && $stable(res_lo_q)));
  // R3
  start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctrl && !en_q && state_q != ST_CONV) |=> (state_q != ST_CONV));
  // R5
  flag_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(done));
  // R5
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> (state_q == ST_IDLE && flag_q));
  // R9
  recov_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RECOV && !conv_tick_i) |=> (state_q == ST_RECOV));
endmodule

// File: tb/test_adc_seq_ctrl.sv
module test_adc_seq_ctrl;
  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       wr_en_i;
  logic [1:0] addr_i;
  logic [7:0] wdata_i;
  logic [7:0] rdata_o;
  logic       conv_tick_i;
  logic       cmp_i;
  logic       sample_o;
  logic [9:0] dac_code_o;
  logic       irq_o;

  logic [9:0] analog;
  int         n_chk = 0;
  int         n_fail = 0;
  int         tick_cnt = 0;
  bit         finished = 0;

  always #5 clk_i = ~clk_i;

  assign cmp_i = (analog >= dac_code_o);

  adc_seq_ctrl i_adc_seq_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .conv_tick_i(conv_tick_i),
    .cmp_i(cmp_i), .sample_o(sample_o), .dac_code_o(dac_code_o), .irq_o(irq_o)
  );

  always @(posedge clk_i) if (rst_ni && conv_tick_i) tick_cnt <= tick_cnt + 1;

  initial begin
    conv_tick_i = 1'b0;
    forever begin
      repeat (3) @(negedge clk_i);
      conv_tick_i = 1'b1;
      @(negedge clk_i);
      conv_tick_i = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mk(bit en, bit go, bit fmt, bit ie, bit flag);
    return {3'b000, flag, ie, fmt, go, en};
  endfunction

  function automatic logic [15:0] exp_pack(logic [9:0] v, bit right);
    return right ? {6'b0, v} : {v, 6'b0};
  endfunction

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr_i = a;
    #1;
    d = rdata_o;
  endtask

  task automatic wait_ticks(input int n);
    int base = tick_cnt;
    while (tick_cnt < base + n) @(negedge clk_i);
  endtask

  task automatic run_conv(input logic [9:0] v, input bit fmt, input bit ie);
    logic [7:0] c, hi, lo;
    logic [15:0] e;
    int snap, guard;
    analog = v;
    wr(2'd0, mk(1, 1, fmt, ie, 1));
    snap = tick_cnt;
    rd(2'd0, c);
    chk(c[1] == 1'b1 && sample_o == 1'b0, "R2 busy/sample at start", {c[1], sample_o}, 2);
    guard = 0;
    while (c[1] && guard < 300) begin
      @(negedge clk_i);
      rd(2'd0, c);
      guard++;
    end
    chk(tick_cnt - snap == 11, "R4 tick count", tick_cnt - snap, 11);
    e = exp_pack(v, fmt);
    rd(2'd1, hi);
    rd(2'd2, lo);
    chk({hi, lo} == e, $sformatf("R4 R6 result fmt=%0d", fmt), {hi, lo}, e);
    chk(c[4] == 1'b1 && sample_o == 1'b1, "R5 flag/sample after done", {c[4], sample_o}, 3);
    chk(irq_o == ie, "R7 irq follows ie", irq_o, ie);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] c, hi, lo, hi0, lo0;
    int snap, bad;
    void'($urandom(32'h5eed_1234));
    rst_ni = 1'b0; wr_en_i = 1'b0; addr_i = 2'd0; wdata_i = 8'h00; analog = 10'd0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), c);
      chk(c == 8'h00, $sformatf("R1 reset reg %0d", a), c, 0);
    end
    chk(irq_o == 1'b0 && sample_o == 1'b0, "R1 reset outputs", {irq_o, sample_o}, 0);

    // R3 start while disabled / combined write
    wr(2'd0, mk(0, 1, 0, 0, 0));
    rd(2'd0, c);
    chk(c[1] == 1'b0, "R3 start while disabled", c[1], 0);
    wr(2'd0, mk(1, 1, 0, 0, 0));
    rd(2'd0, c);
    chk(c[1] == 1'b0, "R3 enable+start same write", c[1], 0);
    repeat (20) @(negedge clk_i);
    rd(2'd0, c);
    chk(c[1] == 1'b0 && c[0] == 1'b1 && sample_o == 1'b1, "R3 no late start, R1 enable reads",
        c[2:0], 1);

    // directed corners
    run_conv(10'd0, 0, 0);
    run_conv(10'd1023, 1, 0);
    run_conv(10'd512, 0, 1);
    run_conv(10'd511, 1, 1);
    run_conv(10'd1, 0, 0);

    // R7 flag sticky and clear
    wr(2'd0, mk(1, 0, 0, 1, 1));
    rd(2'd0, c);
    chk(c[4] == 1'b1 && irq_o == 1'b1, "R7 flag kept on write 1", {c[4], irq_o}, 3);
    wr(2'd0, mk(1, 0, 0, 1, 0));
    rd(2'd0, c);
    chk(c[4] == 1'b0 && irq_o == 1'b0, "R7 flag cleared", {c[4], irq_o}, 0);

    // random conversions
    for (int k = 0; k < 20; k++) begin
      logic [9:0] v = 10'($urandom);
      bit f = 1'($urandom);
      bit ie = 1'($urandom);
      run_conv(v, f, ie);
    end

    // R8 abort via busy clear
    wr(2'd0, mk(1, 0, 0, 0, 0));
    rd(2'd1, hi0); rd(2'd2, lo0);
    analog = 10'd777;
    wr(2'd0, mk(1, 1, 0, 0, 0));
    wait_ticks(5);
    wr(2'd0, mk(1, 0, 0, 0, 0));
    snap = tick_cnt;
    rd(2'd0, c); rd(2'd1, hi); rd(2'd2, lo);
    chk(c[1] == 1'b0 && c[4] == 1'b0, "R8 busy/flag after abort", {c[1], c[4]}, 0);
    chk({hi, lo} == {hi0, lo0}, "R8 result kept", {hi, lo}, {hi0, lo0});
    // R9 start ignored in recovery
    wr(2'd0, mk(1, 1, 0, 0, 0));
    rd(2'd0, c);
    chk(c[1] == 1'b0, "R9 start ignored in recovery", c[1], 0);
    bad = 0;
    while (tick_cnt < snap + 2) begin
      if (sample_o) bad++;
      @(negedge clk_i);
    end
    chk(bad == 0, "R9 sample open during delay", bad, 0);
    chk(sample_o == 1'b1, "R9 sample closes after delay", sample_o, 1);
    rd(2'd0, c);
    chk(c[1] == 1'b0, "R9 no deferred start", c[1], 0);
    run_conv(10'd300, 1, 0);

    // R10 disable mid-conversion
    rd(2'd1, hi0); rd(2'd2, lo0);
    analog = 10'd45;
    wr(2'd0, mk(1, 1, 0, 0, 0));
    wait_ticks(3);
    wr(2'd0, mk(0, 0, 0, 0, 0));
    rd(2'd0, c); rd(2'd1, hi); rd(2'd2, lo);
    chk(c[1] == 1'b0 && sample_o == 1'b0, "R10 busy/sample after disable", {c[1], sample_o}, 0);
    chk({hi, lo} == {hi0, lo0}, "R10 result kept", {hi, lo}, {hi0, lo0});
    chk(c[4] == 1'b0, "R10 flag not set", c[4], 0);
    wait_ticks(3);
    chk(sample_o == 1'b0, "R10 sample open while disabled", sample_o, 0);
    wr(2'd0, mk(1, 0, 0, 0, 0));
    chk(sample_o == 1'b1, "R10 sample after re-enable", sample_o, 1);
    run_conv(10'd45, 0, 1);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule